// File: doc/BRIEF.md
# Host-Register SPI Flash Command Engine

This block is an SPI master that a host drives through eight byte-wide I/O registers sitting at a base port supplied on an input. The host first loads an opcode, up to three address bytes and one optional extra byte into the data registers. It then writes a control byte that starts the transfer and also carries the write length, the number of bytes to read back and the clock rate. The engine drops chip select, shifts the write bytes out, clocks in the requested response bytes, stores them in readable registers and raises chip select again. While it is working, a busy flag is visible to the host.

The write length uses a compact 2-bit code that allows only 1, 2, 4 or 5 bytes. The address bytes are held in the registers in the reverse of the order in which they go onto the wire. A second start code opens a page-program window. In this mode the engine sends the opcode and address and then keeps chip select low. After that, each host write to the data port sends one more flash data byte, up to one page. A control write of zero closes the window.

Top module: `hostreg_spi_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the status byte at offset 0 reads 0x00 and the data registers read 0x00.
- R2: Bit 7 of offset 0 reads 1 from the first cycle after a start write until the transfer ends. Chip select rises, and busy clears, exactly one system clock after the last falling serial clock edge.
- R3: The control bits [1:0] select the write length: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 5. The opcode at offset 1 always goes first. The second byte of a 2-byte command and the fifth byte of a 5-byte command come from offset 7. The address bytes of 4- and 5-byte commands are sent in the order offset 4, offset 3, offset 2.
- R4: The control bits [3:2] give a read count of 0 to 3 bytes. These bytes are clocked in after the write bytes and stored at offsets 5, 6 and 7 in the order they arrive.
- R5: A control value with bits [7:4] = 0100 starts a command with a serial clock half-period of SLOW_HALF system clocks. A value with bits [7:4] = 0101 uses FAST_HALF system clocks. Any other value, apart from the window codes in R8, starts nothing.
- R6: The serial link uses SPI mode 0: the clock idles low, each bit is driven most significant bit first, and each bit is stable at the rising clock edge where both sides sample it. Data sent during the read phase is zero.
- R7: A control write while busy reads 1 is ignored, and the running transfer keeps its length.
- R8: Control value 0x20 (slow) or 0x30 (fast) sends offset 1, then offsets 4, 3 and 2. Chip select then stays low and busy clears. Each later write to offset 7 sends that byte, and busy reads 1 until the byte has been shifted out.
- R9: After PAGE_BYTES data bytes, further writes to offset 7 send nothing. A control write of 0x00 while the window is open raises chip select.
- R10: The block responds to a host access only when address bits [15:3] match the base port input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_port | input | AW | Base I/O port; the low 3 bits are ignored |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | AW | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational; 0 when not selected) |
| spi_sck | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with SLOW_HALF = 3 and FAST_HALF = 1. With these values the two rates give clearly different rising-edge spacings of 6 and 2 system clocks, and both are measured on every command. FAST_HALF = 1 also tests a divider that fires on every cycle. PAGE_BYTES keeps its default of 256, so the bench runs a complete page window and then sends one extra byte to check the cut-off. A responder in the bench returns a byte pattern that changes with the transaction. This lets the bench show that captured bytes land at the right offsets in arrival order for every combination of write code and read count.

// File: rtl/hostreg_spi_engine.sv
module hostreg_spi_engine #(
  parameter int AW         = 16,
  parameter int SLOW_HALF  = 4,
  parameter int FAST_HALF  = 2,
  parameter int PAGE_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_port,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          spi_sck,
  output logic          spi_csn,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CW   = (MAXH > 1) ? $clog2(MAXH) : 1;
  localparam int PCW  = $clog2(PAGE_BYTES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LAST, S_WIN} st_t;

  st_t            st;
  logic [7:0]     regs [1:7];
  logic [7:0]     txq  [0:4];
  logic [7:0]     tx_n [0:4];
  logic [2:0]     nwr, nwr_n, bitc;
  logic [3:0]     nbytes, bidx;
  logic [7:0]     shreg, rxsh;
  logic           fast, win;
  logic [CW-1:0]  dcnt;
  logic [PCW-1:0] pcnt;

  wire       hit     = io_addr[AW-1:3] == base_port[AW-1:3];
  wire [2:0] off     = io_addr[2:0];
  wire       busy    = (st == S_SHIFT) || (st == S_LAST);
  wire       ctrl_wr = io_wr && hit && (off == 3'd0);
  wire       go_cmd  = ctrl_wr && (st == S_IDLE) && (io_wdata[7:5] == 3'b010);
  wire       go_pp   = ctrl_wr && (st == S_IDLE) && (io_wdata[7:5] == 3'b001) && (io_wdata[3:0] == 4'd0);
  wire       pp_end  = ctrl_wr && (st == S_WIN) && (io_wdata == 8'd0);
  wire       pp_data = io_wr && hit && (off == 3'd7) && (st == S_WIN) && (pcnt != PCW'(PAGE_BYTES));
  wire       reg_wr  = io_wr && hit && (off != 3'd0) && !((st == S_WIN) && (off == 3'd7));
  wire [CW-1:0] half = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
  wire       tick      = dcnt == half;
  wire       last_byte = bidx == nbytes - 4'd1;
  wire [2:0] nxt       = bidx[2:0] + 3'd1;
  wire [2:0] rx_slot   = bidx[2:0] - nwr + 3'd5;

  assign spi_mosi = shreg[7];
  assign io_rdata = !(io_rd && hit) ? 8'h00 : (off == 3'd0) ? {busy, 7'd0} : regs[off];

  always_comb begin
    case (io_wdata[1:0])
      2'd0:    nwr_n = 3'd1;
      2'd1:    nwr_n = 3'd2;
      2'd2:    nwr_n = 3'd4;
      default: nwr_n = 3'd5;
    endcase
    tx_n[0] = regs[1];
    tx_n[1] = (io_wdata[1:0] == 2'd1) ? regs[7] : regs[4];
    tx_n[2] = regs[3];
    tx_n[3] = regs[2];
    tx_n[4] = regs[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 1; i < 8; i++) regs[i] <= 8'd0;
      for (int i = 0; i < 5; i++) txq[i] <= 8'd0;
      nwr <= 3'd1; nbytes <= 4'd1; bidx <= 4'd0; bitc <= 3'd0;
      shreg <= 8'd0; rxsh <= 8'd0; fast <= 1'b0; win <= 1'b0;
      dcnt <= '0; pcnt <= '0;
      spi_sck <= 1'b0; spi_csn <= 1'b1;
    end else begin
      if (reg_wr) regs[off] <= io_wdata;
      case (st)
        S_IDLE: begin
          if (go_cmd || go_pp) begin
            txq    <= tx_n;
            shreg  <= tx_n[0];
            nwr    <= go_pp ? 3'd4 : nwr_n;
            nbytes <= go_pp ? 4'd4 : {1'b0, nwr_n} + {2'b0, io_wdata[3:2]};
            fast   <= io_wdata[4];
            win    <= go_pp;
            pcnt   <= '0;
            bidx   <= 4'd0;
            bitc   <= 3'd0;
            dcnt   <= '0;
            spi_csn <= 1'b0;
            st     <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!tick) dcnt <= dcnt + CW'(1);
          else begin
            dcnt <= '0;
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rxsh    <= {rxsh[6:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              if (bitc != 3'd7) begin
                bitc  <= bitc + 3'd1;
                shreg <= {shreg[6:0], 1'b0};
              end else begin
                bitc <= 3'd0;
                if (bidx[2:0] >= nwr) regs[rx_slot] <= rxsh;
                if (last_byte) st <= S_LAST;
                else begin
                  bidx  <= bidx + 4'd1;
                  shreg <= (nxt < nwr) ? txq[nxt] : 8'd0;
                end
              end
            end
          end
        end
        S_LAST: begin
          if (win) st <= S_WIN;
          else begin
            spi_csn <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: begin
          if (pp_end) begin
            spi_csn <= 1'b1;
            win     <= 1'b0;
            st      <= S_IDLE;
          end else if (pp_data) begin
            shreg  <= io_wdata;
            nwr    <= 3'd1;
            nbytes <= 4'd1;
            bidx   <= 4'd0;
            bitc   <= 3'd0;
            dcnt   <= '0;
            pcnt   <= pcnt + PCW'(1);
            st     <= S_SHIFT;
          end
        end
      endcase
    end
  end

  assert_idle_cs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> spi_csn);
  assert_busy_end_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (spi_csn != win));
  assert_clock_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);
  assert_ctrl_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> ($stable(nbytes) && $stable(fast)));
  assert_byte_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> (bidx < nbytes));
  assert_page_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PCW'(PAGE_BYTES));
  assert_window_cs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN) |-> !spi_csn);
endmodule

// File: tb/test_hostreg_spi_engine.sv
module test_hostreg_spi_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 3;
  localparam int FH = 1;
  localparam logic [15:0] BASE = 16'h0A38;

  logic clk = 0, rst_n = 0;
  logic io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic spi_sck, spi_csn, spi_mosi, spi_miso = 0;

  hostreg_spi_engine #(.AW(16), .SLOW_HALF(SH), .FAST_HALF(FH), .PAGE_BYTES(256)) i_hostreg_spi_engine (
    .clk(clk), .rst_n(rst_n), .base_port(BASE), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // responder / monitor
  logic [7:0] cap [0:299];
  int ncap = 0, nbits = 0, rises = 0, r0 = 0, r1 = 0, last_fall = 0, cs_rise = 0, cs_falls = 0, bitpos = 0;
  logic [7:0] cur = 0, salt = 0;
  logic p_sck = 0, p_csn = 1;

  function automatic logic [7:0] resp(int i);
    return 8'hA7 ^ 8'(i * 8'h35) ^ salt;
  endfunction

  always @(negedge clk) begin
    if (p_csn && !spi_csn) begin
      cs_falls++; ncap = 0; nbits = 0; rises = 0; bitpos = 0;
      spi_miso <= resp(0)[7];
    end
    if (!p_sck && spi_sck && !spi_csn) begin
      cur = {cur[6:0], spi_mosi};
      nbits++;
      if (nbits % 8 == 0 && ncap < 300) begin cap[ncap] = cur; ncap++; end
      if (rises == 0) r0 = cyc; else if (rises == 1) r1 = cyc;
      rises++;
    end
    if (p_sck && !spi_sck) begin
      bitpos++;
      spi_miso <= resp(bitpos / 8)[7 - (bitpos % 8)];
      last_fall = cyc;
    end
    if (!p_csn && spi_csn) cs_rise = cyc;
    p_sck = spi_sck; p_csn = spi_csn;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_abs(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic host_wr(input logic [2:0] o, input logic [7:0] d);
    wr_abs(BASE + 16'(o), d);
  endtask

  task automatic rd_abs(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    io_rd = 0;
  endtask

  task automatic host_rd(input logic [2:0] o, output logic [7:0] d);
    rd_abs(BASE + 16'(o), d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin host_rd(3'd0, s); n++; end while (s[7] && n < 20000);
    @(negedge clk); #2;
  endtask

  function automatic int wlen(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
  endfunction

  // expected wire byte i given register image b[0]=off1,b[1]=off4,b[2]=off3,b[3]=off2,b[4]=off7
  function automatic logic [7:0] wire_byte(input int i, input int code, input logic [7:0] b [5]);
    if (i == 0) return b[0];
    if (code == 1) return b[4];
    return b[i];
  endfunction

  task automatic do_cmd(input int code, input int rc, input bit fst);
    logic [7:0] b [5];
    logic [7:0] s;
    int wn, f0, bad;
    for (int i = 0; i < 5; i++) b[i] = 8'($urandom);
    salt = 8'($urandom);
    host_wr(3'd1, b[0]); host_wr(3'd4, b[1]); host_wr(3'd3, b[2]);
    host_wr(3'd2, b[3]); host_wr(3'd7, b[4]);
    wn = wlen(code);
    f0 = cs_falls;
    host_wr(3'd0, {1'b0, 2'b10, fst, 2'(rc), 2'(code)});
    host_rd(3'd0, s);
    check(s == 8'h80, "R2 busy reads 1 during transfer", s, 8'h80);
    wait_idle();
    check(cs_falls == f0 + 1 && ncap == wn + rc, "R3 R4 byte count on wire", ncap, wn + rc);
    bad = 0;
    for (int i = 0; i < wn; i++) if (cap[i] != wire_byte(i, code, b)) bad++;
    for (int i = wn; i < wn + rc; i++) if (cap[i] != 8'h00) bad++;
    check(bad == 0, "R3 R6 wire order and read-phase zero", bad, 0);
    for (int k = 0; k < rc; k++) begin
      host_rd(3'(5 + k), s);
      check(s == resp(wn + k), "R4 captured byte", s, resp(wn + k));
    end
    check(r1 - r0 == 2 * (fst ? FH : SH), "R5 clock period", r1 - r0, 2 * (fst ? FH : SH));
    check(cs_rise - last_fall == 1 && spi_csn, "R2 cs release after last bit", cs_rise - last_fall, 1);
    check(!spi_sck, "R6 clock idles low", spi_sck, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    failures++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [7:0] pg [0:255];
    logic [7:0] hdr [4];
    int f0, bad, busy_bad;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(spi_csn && !spi_sck, "R1 reset pins", {spi_csn, spi_sck}, 2'b10);
    host_rd(3'd0, s); check(s == 8'h00, "R1 reset status", s, 0);
    host_rd(3'd5, s); check(s == 8'h00, "R1 reset data reg", s, 0);

    // directed: every write code with every read count, both rates
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) do_cmd(c, r, (c + r) % 2 == 1);
    // random mix
    for (int n = 0; n < 12; n++) do_cmd(int'($urandom % 4), int'($urandom % 4), 1'($urandom));

    // R7: control write while busy is ignored
    f0 = cs_falls;
    host_wr(3'd0, 8'h40);
    host_wr(3'd0, 8'h5F);
    wait_idle();
    check(ncap == 1 && cs_falls == f0 + 1, "R7 busy control write ignored", ncap, 1);

    // R5: invalid start codes do nothing
    f0 = cs_falls;
    host_wr(3'd0, 8'h60); host_wr(3'd0, 8'hC0); host_wr(3'd0, 8'h21);
    repeat (20) @(negedge clk);
    check(cs_falls == f0 && spi_csn, "R5 invalid control ignored", cs_falls - f0, 0);

    // R10: address outside the 8-port window
    f0 = cs_falls;
    wr_abs(BASE + 16'd8, 8'h40);
    wr_abs(BASE - 16'd8, 8'h50);
    repeat (20) @(negedge clk);
    check(cs_falls == f0, "R10 foreign address ignored", cs_falls - f0, 0);
    host_wr(3'd2, 8'h5A);
    rd_abs(BASE + 16'd10, s); check(s == 8'h00, "R10 foreign read returns zero", s, 0);
    host_rd(3'd2, s); check(s == 8'h5A, "R10 own read returns register", s, 8'h5A);

    // R8: page-program window
    hdr[0] = 8'h02; hdr[1] = 8'h12; hdr[2] = 8'h34; hdr[3] = 8'h56;
    host_wr(3'd1, hdr[0]); host_wr(3'd4, hdr[1]); host_wr(3'd3, hdr[2]); host_wr(3'd2, hdr[3]);
    f0 = cs_falls;
    host_wr(3'd0, 8'h30);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 4; i++) if (cap[i] != hdr[i]) bad++;
    check(ncap == 4 && bad == 0, "R8 window header bytes", ncap, 4);
    check(!spi_csn, "R8 cs held low after header", spi_csn, 0);
    busy_bad = 0;
    for (int i = 0; i < 256; i++) begin
      pg[i] = 8'($urandom);
      host_wr(3'd7, pg[i]);
      host_rd(3'd0, s);
      if (s != 8'h80) busy_bad++;
      wait_idle();
    end
    check(busy_bad == 0, "R8 busy held per data byte", busy_bad, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (cap[4 + i] != pg[i]) bad++;
    check(ncap == 260 && bad == 0 && cs_falls == f0 + 1, "R8 streamed page data", ncap, 260);
    host_wr(3'd7, 8'hEE);
    repeat (40) @(negedge clk);
    check(ncap == 260, "R9 data after full page ignored", ncap, 260);
    check(!spi_csn, "R9 window still open", spi_csn, 0);
    host_wr(3'd0, 8'h00);
    @(negedge clk);
    check(spi_csn, "R9 zero control closes window", spi_csn, 1);

    // slow window, closed early
    host_wr(3'd0, 8'h20);
    wait_idle();
    host_wr(3'd7, 8'hA5);
    wait_idle();
    check(ncap == 5 && cap[4] == 8'hA5 && r1 - r0 == 2 * SH, "R8 slow window data byte", cap[4], 8'hA5);
    host_wr(3'd0, 8'h00);
    @(negedge clk);
    check(spi_csn, "R9 early close", spi_csn, 1);

    do_cmd(3, 3, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule